// File: doc/BRIEF.md
# I/O Rail Deep-Powerdown Controller

This block is a register-mapped controller on an APB slave port. It moves I/O pad rails into and out of deep powerdown. The rails are arranged in two banks of thirty. Each bank has a request register and a status register. Software first sets the sampling bit and programs a settle time in APB clock cycles. It then writes a request word whose top two bits hold a command and whose low thirty bits pick rails.

A request that starts a transition loads a shared down-counter. When the count runs out, every selected rail of the addressed bank changes state together. The new state shows up at once in the status register and on the per-rail output vector that drives the pad logic. Only one transition is in flight at a time. A second request write that arrives while one is pending is held with PREADY low until the first one completes.

Top module: `iorail_dpd_ctrl`

## Requirements
- R1: After reset, every rail is out of deep powerdown. `rail_dpd` is all zero, and every register (sample 0x020, timing 0x1C8, requests 0x1B8/0x1C0, status 0x1BC/0x1C4) reads 0.
- R2: A request register reads back the full 32-bit word last written to it. The sample register reads back bit 0, and the timing register reads back its low 16 bits. Accesses that are not request writes complete with PREADY high.
- R3: A request with command 2 (bits 31:30 = 2'b10), written while sampling is on, sets the status bits of the selected rails in the addressed bank. The change happens exactly N clock edges after the accepting edge, where N is the timing value. Until then, status reads still return the old value.
- R4: A request with command 1 (bits 31:30 = 2'b01) clears the status bits of the selected rails after the same delay. Unselected rails keep their state.
- R5: Only request bits 29:0 select rails, bit i meaning rail i of that bank. Status bits 31:30 always read 0.
- R6: A request with command 0 or command 3 changes no rail state.
- R7: While sample bit 0 is clear, no request changes any rail state. The request word is still stored.
- R8: A timing value of 0 behaves as a one-cycle settle time.
- R9: A request write that arrives while a transition is pending is held with PREADY low. It is accepted on the edge after the pending transition completes.
- R10: Writes to the status registers are ignored.
- R11: `rail_dpd[30*b+i]` equals status bit i of bank b at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock, also the settle-time clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Low while a request write waits for a pending transition |
| rail_dpd | output | 60 | Per-rail deep-powerdown state, bank 0 in bits 29:0 |

## Verification
Two things can fall on the same clock edge: the end of one transition and the arrival of the next request write. The bench provokes this by issuing a second request right behind the first. It then judges three things: the second write stays stalled through the completion cycle, it is accepted exactly one edge after completion, and its own state change follows N edges after that. A scoreboard timestamps every change on `rail_dpd` against the cycle the bench predicts. Status reads made in the middle of a pending transition must still return the old value.

// File: rtl/iorail_pkg.sv
package iorail_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CMD_LSB = 30;

  localparam logic [11:0] OFF_SAMPLE    = 12'h020;
  localparam logic [11:0] OFF_REQ_BASE  = 12'h1B8;
  localparam logic [11:0] OFF_STAT_BASE = 12'h1BC;
  localparam logic [11:0] OFF_TIMING    = 12'h1C8;
  localparam logic [11:0] BANK_STRIDE   = 12'h008;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_EXIT  = 2'd1,
    CMD_ENTER = 2'd2,
    CMD_RSVD  = 2'd3
  } dpd_cmd_e;
endpackage

// File: rtl/iorail_rst_sync.sv
module iorail_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/iorail_settle_timer.sv
module iorail_settle_timer #(
  parameter int unsigned TIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TIM_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic [TIM_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;
  logic [TIM_W-1:0] eff_load;

  // a zero setting still waits one edge
  assign eff_load = (load_val == '0) ? TIM_W'(1) : load_val;
  assign done     = busy_q && (cnt_q == TIM_W'(1));
  assign cnt_en   = start || busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = eff_load;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == TIM_W'(1)) begin
        cnt_d  = '0;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - TIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/iorail_rail_bank.sv
module iorail_rail_bank #(
  parameter int unsigned RAILS = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic             enter,
  input  logic [RAILS-1:0] sel,
  output logic [RAILS-1:0] state
);
  logic [RAILS-1:0] state_q;

  for (genvar i = 0; i < RAILS; i++) begin : g_rail
    logic rail_en;
    logic rail_d;
    assign rail_en = apply && sel[i];
    assign rail_d  = enter;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q[i] <= 1'b0;
      else if (rail_en) state_q[i] <= rail_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/iorail_apb_regs.sv
module iorail_apb_regs
  import iorail_pkg::*;
#(
  parameter int unsigned NBANK  = 2,
  parameter int unsigned RAILS  = 30,
  parameter int unsigned TIM_W  = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BANK_W = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [ADDR_W-1:0]      paddr,
  input  logic [WORD_W-1:0]      pwdata,
  output logic [WORD_W-1:0]      prdata,
  output logic                   pready,
  input  logic                   busy,
  input  logic [NBANK*RAILS-1:0] status_in,
  output logic [TIM_W-1:0]       tim_val,
  output logic                   start,
  output logic [BANK_W-1:0]      start_bank,
  output dpd_cmd_e               start_cmd,
  output logic [RAILS-1:0]       start_sel
);
  logic [NBANK-1:0]  hit_req, hit_stat;
  logic              hit_sample, hit_timing, any_req;
  logic              stall, commit;
  logic [WORD_W-1:0] req_q [NBANK];
  logic              sample_q, sample_d, sample_en;
  logic [TIM_W-1:0]  tim_q, tim_d;
  logic              tim_en;

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign hit_req[b]  = (paddr == ADDR_W'(OFF_REQ_BASE  + BANK_STRIDE * b));
    assign hit_stat[b] = (paddr == ADDR_W'(OFF_STAT_BASE + BANK_STRIDE * b));
  end

  assign hit_sample = (paddr == ADDR_W'(OFF_SAMPLE));
  assign hit_timing = (paddr == ADDR_W'(OFF_TIMING));
  assign any_req    = |hit_req;

  assign stall  = psel && pwrite && any_req && busy;
  assign pready = !stall;
  assign commit = psel && penable && pwrite && !stall;

  for (genvar b = 0; b < NBANK; b++) begin : g_req
    logic              req_en;
    logic [WORD_W-1:0] req_d;
    assign req_en = commit && hit_req[b];
    assign req_d  = pwdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req_q[b] <= '0;
      else if (req_en) req_q[b] <= req_d;
    end
  end

  assign sample_en = commit && hit_sample;
  assign sample_d  = pwdata[0];
  assign tim_en    = commit && hit_timing;
  assign tim_d     = pwdata[TIM_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sample_q <= 1'b0;
    else if (sample_en) sample_q <= sample_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tim_q <= '0;
    else if (tim_en) tim_q <= tim_d;
  end

  always_comb begin
    start_bank = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit_req[b]) start_bank = BANK_W'(b);
    end
  end

  assign start_cmd = dpd_cmd_e'(pwdata[WORD_W-1 -: 2]);
  assign start_sel = pwdata[RAILS-1:0];
  assign start     = commit && any_req && sample_q &&
                     ((start_cmd == CMD_ENTER) || (start_cmd == CMD_EXIT));
  assign tim_val   = tim_q;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_sample) prdata[0] = sample_q;
      if (hit_timing) prdata[TIM_W-1:0] = tim_q;
      for (int b = 0; b < NBANK; b++) begin
        if (hit_req[b])  prdata = req_q[b];
        if (hit_stat[b]) prdata[RAILS-1:0] = status_in[b*RAILS +: RAILS];
      end
    end
  end
endmodule

// File: rtl/iorail_dpd_ctrl.sv
module iorail_dpd_ctrl
  import iorail_pkg::*;
#(
  parameter int unsigned NBANK  = 2,
  parameter int unsigned RAILS  = 30,
  parameter int unsigned TIM_W  = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                   pclk,
  input  logic                   presetn,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [ADDR_W-1:0]      paddr,
  input  logic [31:0]            pwdata,
  output logic [31:0]            prdata,
  output logic                   pready,
  output logic [NBANK*RAILS-1:0] rail_dpd
);
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int unsigned NRAIL  = NBANK * RAILS;

  logic              rst_sync_n;
  logic              tmr_busy, tmr_done, tmr_start;
  logic [TIM_W-1:0]  tim_val;
  logic [BANK_W-1:0] st_bank;
  dpd_cmd_e          st_cmd;
  logic [RAILS-1:0]  st_sel;
  logic [NRAIL-1:0]  status_all;

  logic [BANK_W-1:0] pend_bank_q, pend_bank_d;
  dpd_cmd_e          pend_cmd_q, pend_cmd_d;
  logic [RAILS-1:0]  pend_sel_q, pend_sel_d;

  iorail_rst_sync u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_sync_n)
  );

  iorail_apb_regs #(
    .NBANK (NBANK), .RAILS (RAILS), .TIM_W (TIM_W),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_regs (
    .clk        (pclk),
    .rst_n      (rst_sync_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .pready     (pready),
    .busy       (tmr_busy),
    .status_in  (status_all),
    .tim_val    (tim_val),
    .start      (tmr_start),
    .start_bank (st_bank),
    .start_cmd  (st_cmd),
    .start_sel  (st_sel)
  );

  iorail_settle_timer #(.TIM_W(TIM_W)) u_tmr (
    .clk      (pclk),
    .rst_n    (rst_sync_n),
    .start    (tmr_start),
    .load_val (tim_val),
    .busy     (tmr_busy),
    .done     (tmr_done)
  );

  // pending transition slot, loaded only when a new one starts
  always_comb begin
    pend_bank_d = st_bank;
    pend_cmd_d  = st_cmd;
    pend_sel_d  = st_sel;
  end

  always_ff @(posedge pclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_bank_q <= '0;
      pend_cmd_q  <= CMD_IDLE;
      pend_sel_q  <= '0;
    end else if (tmr_start) begin
      pend_bank_q <= pend_bank_d;
      pend_cmd_q  <= pend_cmd_d;
      pend_sel_q  <= pend_sel_d;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_apply;
    assign bank_apply = tmr_done && (pend_bank_q == BANK_W'(b));
    iorail_rail_bank #(.RAILS(RAILS)) u_bank (
      .clk   (pclk),
      .rst_n (rst_sync_n),
      .apply (bank_apply),
      .enter (pend_cmd_q == CMD_ENTER),
      .sel   (pend_sel_q),
      .state (status_all[b*RAILS +: RAILS])
    );
  end

  assign rail_dpd = status_all;
endmodule

// File: rtl/iorail_dpd_chk.sv
module iorail_dpd_chk
  import iorail_pkg::*;
#(
  parameter int unsigned NBANK  = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NRAIL  = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              pready,
  input logic              busy,
  input logic              done,
  input logic              start,
  input logic [NRAIL-1:0]  rail_dpd
);
  logic req_hit;
  always_comb begin
    req_hit = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (paddr == ADDR_W'(OFF_REQ_BASE + BANK_STRIDE * b)) req_hit = 1'b1;
    end
  end

  // R9
  stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && req_hit && busy) |-> !pready);

  // R9
  single_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R3
  change_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rail_dpd));

  // R2
  nonreq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !(pwrite && req_hit)) |-> pready);

  // R8
  start_arms_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

bind iorail_dpd_ctrl iorail_dpd_chk #(
  .NBANK(NBANK), .ADDR_W(ADDR_W), .NRAIL(NBANK*RAILS)
) u_chk (
  .clk      (pclk),
  .rst_n    (rst_sync_n),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pready   (pready),
  .busy     (tmr_busy),
  .done     (tmr_done),
  .start    (tmr_start),
  .rail_dpd (rail_dpd)
);

// File: tb/tb_iorail_dpd_ctrl.sv
module tb_iorail_dpd_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready;
  logic [59:0] rail_dpd;

  iorail_dpd_ctrl dut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .rail_dpd(rail_dpd)
  );

  always #2.5ns clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [59:0] model = '0;
  logic        sample_on = 1'b0;
  int unsigned tim_n = 0;
  bit          mon_on = 1'b0;
  logic [59:0] last_seen = '0;
  bit          finished = 1'b0;

  typedef struct {
    logic [59:0] vec;
    int unsigned at;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every change on rail_dpd must match the next expected item
  always @(negedge clk) begin
    if (mon_on && rail_dpd !== last_seen) begin
      if (sbq.size() == 0) begin
        check("R3 unexpected rail change", {4'h0, rail_dpd}, {4'h0, last_seen});
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " value"}, {4'h0, rail_dpd}, {4'h0, e.vec});
        check({e.tag, " cycle"}, 64'(cyc), 64'(e.at));
      end
      last_seen = rail_dpd;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d, output int unsigned acc);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    while (!pready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [11:0] req_addr(input int b);
    return 12'(12'h1B8 + 8 * b);
  endfunction

  function automatic logic [11:0] stat_addr(input int b);
    return 12'(12'h1BC + 8 * b);
  endfunction

  // driver: issue a request and push the expected result into the scoreboard
  task automatic request(input int b, input logic [1:0] cmd, input logic [29:0] sel,
                         input string tag, output int unsigned acc);
    logic [59:0] nxt;
    int unsigned n_eff;
    apb_write(req_addr(b), {cmd, sel}, acc);
    n_eff = (tim_n == 0) ? 1 : tim_n;
    nxt = model;
    if (sample_on && (cmd == 2'd2 || cmd == 2'd1)) begin
      for (int i = 0; i < 30; i++) begin
        if (sel[i]) nxt[b*30 + i] = (cmd == 2'd2);
      end
      if (nxt != model) sbq.push_back('{vec: nxt, at: acc + n_eff, tag: tag});
      model = nxt;
    end
  endtask

  initial begin
    #(200000 * 5ns);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int unsigned a1, a2, dummy;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    presetn = 1'b0;
    wait_cyc(4);
    presetn = 1'b1;
    wait_cyc(4);
    last_seen = rail_dpd;
    mon_on = 1'b1;

    // R1 reset state
    check("R1 rail_dpd", {4'h0, rail_dpd}, 64'h0);
    apb_read(12'h1BC, rd); check("R1 status0", 64'(rd), 64'h0);
    apb_read(12'h1C4, rd); check("R1 status1", 64'(rd), 64'h0);
    apb_read(12'h020, rd); check("R1 sample", 64'(rd), 64'h0);
    apb_read(12'h1C8, rd); check("R1 timing", 64'(rd), 64'h0);
    apb_read(12'h1B8, rd); check("R1 request0", 64'(rd), 64'h0);

    // R7 sampling off: request stored, no transition
    request(0, 2'd2, 30'h1, "R7", dummy);
    wait_cyc(5);
    apb_read(12'h1BC, rd); check("R7 status0 unchanged", 64'(rd), 64'h0);
    apb_read(12'h1B8, rd); check("R7 request stored", 64'(rd), 64'h8000_0001);

    // R2 sample and timing readback
    apb_write(12'h020, 32'h1, dummy); sample_on = 1'b1;
    apb_write(12'h1C8, 32'h5, dummy); tim_n = 5;
    apb_read(12'h020, rd); check("R2 sample readback", 64'(rd), 64'h1);
    apb_read(12'h1C8, rd); check("R2 timing readback", 64'(rd), 64'h5);

    // R3 enter, status unchanged mid-settle
    request(0, 2'd2, 30'h2000_0009, "R3 enter bank0", a1);
    apb_read(12'h1BC, rd); check("R3 status old while pending", 64'(rd), 64'h0);
    wait_cyc(6);
    apb_read(12'h1BC, rd); check("R3 status0 after enter", 64'(rd), 64'h2000_0009);
    apb_read(12'h1B8, rd); check("R2 request0 readback", 64'(rd), 64'hA000_0009);

    // R4 exit one rail
    request(0, 2'd1, 30'h8, "R4 exit bank0", a1);
    wait_cyc(7);
    apb_read(12'h1BC, rd); check("R4 status0 after exit", 64'(rd), 64'h2000_0001);

    // R11 bank 1 mapping on rail_dpd
    request(1, 2'd2, 30'h2000_0001, "R11 enter bank1", a1);
    wait_cyc(7);
    apb_read(12'h1C4, rd); check("R11 status1", 64'(rd), 64'h2000_0001);
    check("R11 rail_dpd mirror", {4'h0, rail_dpd}, {4'h0, model});
    check("R11 rail 59", 64'(rail_dpd[59]), 64'h1);

    // R5 all selects: status bits 31:30 stay zero
    request(1, 2'd2, 30'h3FFF_FFFF, "R5 enter all bank1", a1);
    wait_cyc(7);
    apb_read(12'h1C4, rd); check("R5 status1 all", 64'(rd), 64'h3FFF_FFFF);
    request(1, 2'd1, 30'h3FFF_FFFF, "R5 exit all bank1", a1);
    wait_cyc(7);
    apb_read(12'h1C4, rd); check("R5 status1 clear", 64'(rd), 64'h0);

    // R6 idle and reserved codes
    request(0, 2'd0, 30'h00FF, "R6 idle", a1);
    wait_cyc(7);
    request(0, 2'd3, 30'h00FF, "R6 reserved", a1);
    wait_cyc(7);
    apb_read(12'h1BC, rd); check("R6 status0 unchanged", 64'(rd), 64'h2000_0001);

    // R10 status write ignored
    apb_write(12'h1BC, 32'h3FFF_FFFF, dummy);
    wait_cyc(2);
    apb_read(12'h1BC, rd); check("R10 status0 read-only", 64'(rd), 64'h2000_0001);
    check("R10 rail_dpd unchanged", {4'h0, rail_dpd}, {4'h0, model});

    // R8 zero timing acts as one cycle
    apb_write(12'h1C8, 32'h0, dummy); tim_n = 0;
    request(0, 2'd2, 30'h2, "R8 one-cycle settle", a1);
    wait_cyc(3);
    apb_read(12'h1BC, rd); check("R8 status0", 64'(rd), 64'h2000_0003);

    // R9 back-to-back: second waits for the first to finish
    apb_write(12'h1C8, 32'h4, dummy); tim_n = 4;
    request(0, 2'd2, 30'h20, "R9 first", a1);
    request(0, 2'd1, 30'h1, "R9 second", a2);
    check("R9 stalled accept cycle", 64'(a2), 64'(a1 + 5));
    wait_cyc(6);
    apb_read(12'h1BC, rd); check("R9 status0 final", 64'(rd), 64'h2000_0022);

    apb_write(12'h020, 32'h0, dummy); sample_on = 1'b0;
    wait_cyc(3);
    check("R3 scoreboard drained", 64'(sbq.size()), 64'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule